// File: doc/BRIEF.md
# Super-Tiled Pixel Address Translator

This block turns a pixel coordinate into a byte offset inside a surface of 32-bit pixels. The surface is stored in one of four tiled layouts. Pixels are always grouped into 4x4 tiles of 64 bytes. In the plain layout the tiles run row by row across the surface. In the super-tiled layout the tiles are nested inside 64x64-pixel super-tiles of 16384 bytes, and the super-tiles run row by row across the surface. Each layout also has a dual-pipe split variant. In a split layout, consecutive tiles alternate between two base addresses, and offsets from the chosen base are halved at tile granularity.

A requester presents `x`, `y`, the layout code and the surface width in pixels, using a valid/ready handshake. The result leaves a two-stage registered pipeline as a base-select bit and a byte offset. A downstream stall back-pressures the pipeline without losing or repeating any request. A combinational flag reports a width or layout code that the selected layout cannot use.

Top module: `stvx_addr_xlate`

## Requirements
- R1: Layout code 1 (plain tiled): offset = ((y/4)*(W/4) + x/4)*64 + ((y%4)*4 + x%4)*4, where W is the width in pixels; base select is 0.
- R2: Layout code 2 (super-tiled): with lx = x%64 and ly = y%64, offset = ((y/64)*(W/64) + x/64)*16384 + ((ly/16)*8 + lx/8)*512 + (((ly%16)/4)*2 + (lx%8)/4)*64 + ((ly%4)*4 + lx%4)*4; base select is 0.
- R3: Layout code 3 (split tiled): take the R1 offset and let n = offset/64 be the tile number in storage order. Base select is n%2 and the output offset is (n/2)*64 + offset%64.
- R4: Layout code 4 (split super-tiled): apply the same split transform to the R2 offset.
- R5: `config_error` is high when the width is not a multiple of 4 in layout codes 1 and 3, or not a multiple of 64 in layout codes 2 and 4. Otherwise it is low for those codes.
- R6: `config_error` is high for any layout code outside 1..4.
- R7: A request accepted on a clock edge appears on `out_valid` after exactly two edges, provided `out_ready` is high.
- R8: While `out_valid` is high and `out_ready` is low, the outputs hold steady. Every accepted request leaves exactly once, in order. `in_ready` is high whenever `out_ready` is high.
- R9: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| px_x | input | XW | Pixel column |
| px_y | input | YW | Pixel row |
| mode | input | 3 | Layout code 1..4 |
| surf_width | input | WW | Surface width in pixels |
| config_error | output | 1 | Width or layout code is unusable |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_base_sel | output | 1 | Selects the second base in split layouts |
| out_offset | output | OW | Byte offset from the selected base |

## Verification
The bench aims at coordinates where each hierarchy level rolls over. These include x at 3/4, 7/8 and 63/64, y at 15/16 and 63/64, and a group boundary inside a super-tile. A design that mixed up the row-major order of groups and tiles, or the x and y bit slices, would produce offsets that jump at these points. Split layouts are checked on consecutive tiles: a wrong base-select bit or a split offset that is not halved shows up as a mismatch on alternating tiles. Random back-pressure on `out_ready` exposes dropped, repeated or reordered results, and outputs that change while stalled. Widths just off the 4- and 64-pixel multiples, and codes 0 and 5..7, check the error flag.

// File: rtl/stvx_pkg.sv
`timescale 1ns/1ps
package stvx_pkg;

    parameter int unsigned PKG_XW = 12;
    parameter int unsigned PKG_YW = 12;
    parameter int unsigned PKG_WW = 13;
    parameter int unsigned PKG_OW = 32;

    typedef enum logic [2:0] {
        LAY_NONE        = 3'd0,
        LAY_TILE        = 3'd1,
        LAY_SUPER       = 3'd2,
        LAY_SPLIT_TILE  = 3'd3,
        LAY_SPLIT_SUPER = 3'd4
    } layout_e;

    // Byte shifts of one 4x4 tile and one 64x64 super-tile (4 bytes per pixel)
    localparam int unsigned TILE_SHIFT  = 6;
    localparam int unsigned SUPER_SHIFT = 14;

    function automatic logic lay_known(input logic [2:0] m);
        return (m >= 3'd1) && (m <= 3'd4);
    endfunction

    function automatic logic lay_super(input logic [2:0] m);
        return (m == LAY_SUPER) || (m == LAY_SPLIT_SUPER);
    endfunction

    function automatic logic lay_split(input logic [2:0] m);
        return (m == LAY_SPLIT_TILE) || (m == LAY_SPLIT_SUPER);
    endfunction

endpackage

// File: rtl/stvx_decomp.sv
`timescale 1ns/1ps
// Splits a coordinate into a unit row, unit column, row pitch in units,
// and the byte offset inside the unit (tile or super-tile).
module stvx_decomp
    import stvx_pkg::*;
#(
    parameter int unsigned XW = PKG_XW,
    parameter int unsigned YW = PKG_YW,
    parameter int unsigned WW = PKG_WW,
    localparam int unsigned ROW_W   = YW - 2,
    localparam int unsigned COL_W   = XW - 2,
    localparam int unsigned PITCH_W = WW - 2
) (
    input  logic [XW-1:0]          px_x,
    input  logic [YW-1:0]          px_y,
    input  logic [2:0]             mode,
    input  logic [WW-1:0]          surf_width,
    output logic [ROW_W-1:0]       row,
    output logic [COL_W-1:0]       col,
    output logic [PITCH_W-1:0]     pitch,
    output logic [SUPER_SHIFT-1:0] inner,
    output logic                   is_super,
    output logic                   is_split
);
    always_comb begin
        is_super = lay_super(mode);
        is_split = lay_split(mode);
        if (is_super) begin
            row   = ROW_W'(px_y >> 6);
            col   = COL_W'(px_x >> 6);
            pitch = PITCH_W'(surf_width >> 6);
            // group row/col, tile row/col in group, pixel row/col, byte
            inner = {px_y[5:4], px_x[5:3], px_y[3:2], px_x[2],
                     px_y[1:0], px_x[1:0], 2'b00};
        end else begin
            row   = ROW_W'(px_y >> 2);
            col   = COL_W'(px_x >> 2);
            pitch = PITCH_W'(surf_width >> 2);
            inner = {8'b0, px_y[1:0], px_x[1:0], 2'b00};
        end
    end
endmodule

// File: rtl/stvx_compose.sv
`timescale 1ns/1ps
// Builds the linear offset from the decomposed fields, then applies the
// dual-pipe split: tile-number LSB picks the base, the rest is halved.
module stvx_compose
    import stvx_pkg::*;
#(
    parameter int unsigned XW = PKG_XW,
    parameter int unsigned YW = PKG_YW,
    parameter int unsigned WW = PKG_WW,
    parameter int unsigned OW = PKG_OW,
    localparam int unsigned ROW_W   = YW - 2,
    localparam int unsigned COL_W   = XW - 2,
    localparam int unsigned PITCH_W = WW - 2,
    localparam int unsigned UNIT_W  = ROW_W + PITCH_W + 1
) (
    input  logic [ROW_W-1:0]       row,
    input  logic [COL_W-1:0]       col,
    input  logic [PITCH_W-1:0]     pitch,
    input  logic [SUPER_SHIFT-1:0] inner,
    input  logic                   is_super,
    input  logic                   is_split,
    output logic                   base_sel,
    output logic [OW-1:0]          offset
);
    logic [UNIT_W-1:0] unit_idx;
    logic [OW-1:0]     linear;
    logic [OW-1:0]     split_off;

    always_comb begin
        unit_idx = UNIT_W'(row) * UNIT_W'(pitch) + UNIT_W'(col);
        if (is_super)
            linear = OW'({unit_idx, inner});
        else
            linear = OW'({unit_idx, inner[TILE_SHIFT-1:0]});
        split_off = {1'b0, linear[OW-1:TILE_SHIFT+1], linear[TILE_SHIFT-1:0]};
        base_sel  = is_split & linear[TILE_SHIFT];
        offset    = is_split ? split_off : linear;
    end
endmodule

// File: rtl/stvx_addr_xlate.sv
`timescale 1ns/1ps
module stvx_addr_xlate
    import stvx_pkg::*;
#(
    parameter int unsigned XW = PKG_XW,
    parameter int unsigned YW = PKG_YW,
    parameter int unsigned WW = PKG_WW,
    parameter int unsigned OW = PKG_OW,
    localparam int unsigned ROW_W   = YW - 2,
    localparam int unsigned COL_W   = XW - 2,
    localparam int unsigned PITCH_W = WW - 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [XW-1:0] px_x,
    input  logic [YW-1:0] px_y,
    input  logic [2:0]    mode,
    input  logic [WW-1:0] surf_width,
    output logic          config_error,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          out_base_sel,
    output logic [OW-1:0] out_offset
);
    typedef struct packed {
        logic [ROW_W-1:0]       row;
        logic [COL_W-1:0]       col;
        logic [PITCH_W-1:0]     pitch;
        logic [SUPER_SHIFT-1:0] inner;
        logic                   is_super;
        logic                   is_split;
    } s1_t;

    s1_t           s1_d, s1_q;
    logic          s1_v;
    logic          s2_en, s1_en;
    logic          c_base;
    logic [OW-1:0] c_off;

    assign s2_en    = !out_valid || out_ready;
    assign s1_en    = !s1_v || s2_en;
    assign in_ready = s1_en;

    always_comb begin
        if (!lay_known(mode))
            config_error = 1'b1;
        else if (lay_super(mode))
            config_error = (surf_width[5:0] != 6'd0);
        else
            config_error = (surf_width[1:0] != 2'd0);
    end

    stvx_decomp #(.XW(XW), .YW(YW), .WW(WW)) decomp_i (
        .px_x      (px_x),
        .px_y      (px_y),
        .mode      (mode),
        .surf_width(surf_width),
        .row       (s1_d.row),
        .col       (s1_d.col),
        .pitch     (s1_d.pitch),
        .inner     (s1_d.inner),
        .is_super  (s1_d.is_super),
        .is_split  (s1_d.is_split)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0;
            s1_q <= '0;
        end else if (s1_en) begin
            s1_v <= in_valid;
            if (in_valid) s1_q <= s1_d;
        end
    end

    stvx_compose #(.XW(XW), .YW(YW), .WW(WW), .OW(OW)) compose_i (
        .row     (s1_q.row),
        .col     (s1_q.col),
        .pitch   (s1_q.pitch),
        .inner   (s1_q.inner),
        .is_super(s1_q.is_super),
        .is_split(s1_q.is_split),
        .base_sel(c_base),
        .offset  (c_off)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_base_sel <= 1'b0;
            out_offset   <= '0;
        end else if (s2_en) begin
            out_valid <= s1_v;
            if (s1_v) begin
                out_base_sel <= c_base;
                out_offset   <= c_off;
            end
        end
    end
endmodule

// File: rtl/stvx_addr_xlate_chk.sv
`timescale 1ns/1ps
module stvx_addr_xlate_chk #(
    parameter int unsigned OW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic [2:0]    mode,
    input logic          config_error,
    input logic          out_valid,
    input logic          out_ready,
    input logic          out_base_sel,
    input logic [OW-1:0] out_offset
);
    // R8: a stalled result stays put
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_offset) && $stable(out_base_sel)));

    // R8: a draining output never blocks the input side
    a_r8_ready_drain: assert property (@(posedge clk) disable iff (rst)
        out_ready |-> in_ready);

    // R7: accepted request reaches the output two edges later when not stalled
    a_r7_latency: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid && in_ready, 2) && $past(out_ready, 1)) |-> out_valid);

    // R6: unknown layout codes always flag an error
    a_r6_bad_code: assert property (@(posedge clk) disable iff (rst)
        ((mode == 3'd0) || (mode > 3'd4)) |-> config_error);
endmodule

bind stvx_addr_xlate stvx_addr_xlate_chk #(.OW(OW)) chk_i (.*);

// File: tb/stvx_addr_xlate_tb_top.sv
`timescale 1ns/1ps
module stvx_addr_xlate_tb_top;
    localparam int XW = 12, YW = 12, WW = 13, OW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, out_ready = 1'b1;
    logic [XW-1:0] px_x = '0;
    logic [YW-1:0] px_y = '0;
    logic [2:0]    mode = 3'd1;
    logic [WW-1:0] surf_width = 13'd256;
    logic in_ready, config_error, out_valid, out_base_sel;
    logic [OW-1:0] out_offset;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [OW:0] exp_q[$];
    int          mode_q[$];
    logic        prev_stall = 0;
    logic [OW:0] prev_out = '0;

    always #2.5 clk = ~clk;

    stvx_addr_xlate dut_i (.*);

    function automatic logic [OW:0] ref_addr(int x, int y, int m, int w);
        longint off, n;
        int lx, ly;
        if (m == 2 || m == 4) begin
            lx = x % 64; ly = y % 64;
            off = longint'((y/64)*(w/64) + x/64) * 16384
                + ((ly/16)*8 + lx/8) * 512
                + (((ly%16)/4)*2 + (lx%8)/4) * 64
                + ((ly%4)*4 + lx%4) * 4;
        end else begin
            off = longint'((y/4)*(w/4) + x/4) * 64 + ((y%4)*4 + x%4) * 4;
        end
        if (m == 3 || m == 4) begin
            n = off / 64;
            return {n[0], 32'((n/2)*64 + off%64)};
        end
        return {1'b0, 32'(off)};
    endfunction

    function automatic string req_of(int m);
        case (m)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, then observe handshakes that the next rising edge takes
    task automatic step(input logic v, input int x, input int y, input int m, input int w, input logic rdy);
        @(negedge clk);
        in_valid = v; px_x = XW'(x); px_y = YW'(y); mode = 3'(m);
        surf_width = WW'(w); out_ready = rdy;
        #1;
        if (prev_stall) // R8 hold while stalled
            chk(out_valid && ({out_base_sel, out_offset} == prev_out), "R8",
                {out_valid, out_base_sel, out_offset}, {1'b1, prev_out});
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) chk(0, "R8", 1, 0); // R8 duplicate/extra result
            else begin
                logic [OW:0] e;
                int em;
                e = exp_q.pop_front(); em = mode_q.pop_front();
                chk({out_base_sel, out_offset} == e, req_of(em), {out_base_sel, out_offset}, e);
            end
        end
        if (in_valid && in_ready) begin
            exp_q.push_back(ref_addr(x, y, m, w));
            mode_q.push_back(m);
        end
        prev_stall = out_valid && !out_ready;
        prev_out   = {out_base_sel, out_offset};
    endtask

    task automatic drain();
        for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 256, 1);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R9 reset state
        chk(!out_valid, "R9", out_valid, 0);
        chk(in_ready, "R9", in_ready, 1);

        // R7 latency: accept, then low one cycle, then high
        step(1, 5, 9, 1, 256, 1);
        step(0, 0, 0, 1, 256, 1);
        chk(!out_valid, "R7", out_valid, 0);
        step(0, 0, 0, 1, 256, 1);
        chk(out_valid, "R7", out_valid, 1);
        drain();

        // Directed rollover corners, all four layouts (R1..R4)
        for (int m = 1; m <= 4; m++) begin
            int xs[8] = '{0, 3, 4, 7, 8, 63, 64, 127};
            int ys[6] = '{0, 3, 15, 16, 63, 64};
            foreach (xs[i]) foreach (ys[j]) step(1, xs[i], ys[j], m, 192, 1);
            step(1, 1023, 4095, m, 1024, 1);
        end
        drain();

        // Consecutive tiles in split layouts: R3 and R4 base alternation
        for (int t = 0; t < 8; t++) step(1, t*4 + 1, 2, 3, 64, 1);
        for (int t = 0; t < 8; t++) step(1, t*4 + 2, 33, 4, 128, 1);
        drain();

        // Random stimulus with random back-pressure (R1..R4, R8)
        for (int i = 0; i < 3000; i++) begin
            int m, w, x, y;
            m = 1 + int'($urandom_range(0, 3));
            w = 64 * (1 + int'($urandom_range(0, 15)));
            x = int'($urandom_range(0, w - 1));
            y = int'($urandom_range(0, 4095));
            step($urandom_range(0, 3) != 0, x, y, m, w, $urandom_range(0, 2) != 0);
        end
        drain();
        chk(exp_q.size() == 0, "R8", exp_q.size(), 0); // R8 nothing lost

        // R5 width multiples, R6 unknown codes
        step(0, 0, 0, 1, 100, 1); chk(!config_error, "R5", config_error, 0);
        step(0, 0, 0, 1, 102, 1); chk(config_error, "R5", config_error, 1);
        step(0, 0, 0, 3, 101, 1); chk(config_error, "R5", config_error, 1);
        step(0, 0, 0, 2, 100, 1); chk(config_error, "R5", config_error, 1);
        step(0, 0, 0, 2, 128, 1); chk(!config_error, "R5", config_error, 0);
        step(0, 0, 0, 4, 96, 1);  chk(config_error, "R5", config_error, 1);
        step(0, 0, 0, 4, 192, 1); chk(!config_error, "R5", config_error, 0);
        step(0, 0, 0, 0, 128, 1); chk(config_error, "R6", config_error, 1);
        step(0, 0, 0, 5, 128, 1); chk(config_error, "R6", config_error, 1);
        step(0, 0, 0, 7, 128, 1); chk(config_error, "R6", config_error, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule